// File: doc/BRIEF.md
# TLB Maintenance Register Port

This block is the special-register window through which a processor core manages its translation lookaside buffer. A 3-bit register select names one of six registers: the entry data word, the entry tag word, the entry index, the search trigger, the process identifier and the zone protection word. Reads and writes arrive as single-cycle strobes. The entry data and tag words are not stored in the port itself. They reach the array slot that the low 8 bits of the index register point at. The port holds the arrays, the per-entry translation identifiers and an associative lookup engine.

Writing the tag word also stamps the entry with the current process identifier. Reading the tag word copies that entry's identifier back into the process identifier register. Writing the search register starts a lookup over all entries, treated as a read in the current privilege mode. Two cycles later the index register holds either the matching entry number or its old contents with bit 31 raised. A configuration input and an access-level input decide which registers can be reached.

Top module: `tlb_mgmt_port`

## Requirements
- R1: After reset the index, process identifier and zone registers and every array word and identifier are zero, so every register reads 0.
- R2: A read strobe gives `rdValid` high in the next cycle, with the value on `rdData`. `rdData` is zero whenever `rdValid` is low. Selects 6 and 7 read as 0 and writes to them do nothing.
- R3: Select 0 (data word) and select 1 (tag word) read and write the array entry named by index bits [7:0]. A tag write also stores the low 8 bits of the process identifier as that entry's identifier.
- R4: A tag-word read (select 1) loads the process identifier (select 4) with the addressed entry's stored identifier.
- R5: A write to select 3 searches for a valid entry whose page matches the written value. An entry matches when its identifier is zero or equals the process identifier. On a hit the index register (select 2) becomes the entry number. The result is visible to a read captured two cycles after the search write.
- R6: On a miss, bit 31 of the index register is set and its other bits keep their value.
- R7: Tag bits [31:10] hold the page number, bit 6 is the valid flag and bits [9:7] are a size code c. The page spans 1 KiB times 4^c, and only address bits at or above 10+2c are compared.
- R8: When several entries match, the lowest entry number wins.
- R9: Data bits [7:4] select zone z. Zone z takes its two-bit field from bits [31-2z:30-2z] of the zone register (select 5). In user mode an entry whose zone field is 00 does not match. In supervisor mode it does.
- R10: Writes to the process identifier, zone and search registers are ignored unless the access level is 2 or 3. Writes to the index, data and tag registers need only a nonzero level.
- R11: With access-level bit 0 clear, reads of the data, tag, process identifier and zone registers return 0, and a tag read leaves the process identifier unchanged. The index register stays readable.
- R12: With the configuration below 2 or the access level 0, all writes are ignored and every read returns 0.
- R13: When index bits [7:0] are not below the entry count, data and tag reads return 0 and data and tag writes are ignored.
- R14: If a direct index write lands in the same cycle as a search result, the direct write is kept and the search result is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| mmuMode | input | 2 | Translation configuration; below 2 disables the port |
| accessLevel | input | 2 | Register access level |
| userMode | input | 1 | Current mode of the core used by searches (1 = user) |
| wrEn | input | 1 | Single-cycle write strobe |
| wrSel | input | 3 | Register select for the write |
| wrValue | input | 32 | Write data |
| rdEn | input | 1 | Single-cycle read strobe |
| rdSel | input | 3 | Register select for the read |
| rdValid | output | 1 | Read result valid, one cycle after rdEn |
| rdData | output | 32 | Read result |

## Verification
A search result reaches the index register two cycles after the search write. Software can write the index register directly in that same cycle. The bench starts a search that would hit, waits one idle cycle, and then writes a distinct value to the index register so that both updates land on the same edge. It then reads the index register at once and again a few cycles later, and expects the directly written value both times. This shows that the search result was dropped and not applied late.

// File: rtl/tlb_mgmt_pkg.sv
package tlb_mgmt_pkg;

  localparam int WORD_W = 32;

  typedef enum logic [2:0] {
    SEL_WORD   = 3'd0,
    SEL_TAG    = 3'd1,
    SEL_INDEX  = 3'd2,
    SEL_SEARCH = 3'd3,
    SEL_PID    = 3'd4,
    SEL_ZONE   = 3'd5
  } reg_sel_e;

  // strobes from decode/control to the datapath
  typedef struct packed {
    logic wrWord;
    logic wrTag;
    logic wrIndex;
    logic wrPid;
    logic wrZone;
    logic search;
    logic rdEn;
    logic rdWord;
    logic rdTag;
    logic rdIndex;
    logic rdPid;
    logic rdZone;
    logic pidLoad;
  } ctrl_stb_t;

endpackage

// File: rtl/tlb_mgmt_ctrl.sv
module tlb_mgmt_ctrl
  import tlb_mgmt_pkg::*;
(
  input  logic       wrEn,
  input  logic [2:0] wrSel,
  input  logic       rdEn,
  input  logic [2:0] rdSel,
  input  logic [1:0] mmuMode,
  input  logic [1:0] accessLevel,
  output ctrl_stb_t  stb
);

  logic portOn;
  logic privWr;
  logic rdPerm;

  assign portOn = (mmuMode >= 2'd2) && (accessLevel != 2'd0);
  assign privWr = accessLevel[1];
  assign rdPerm = accessLevel[0];

  always_comb begin
    stb = '0;
    stb.rdEn = rdEn;
    if (wrEn && portOn) begin
      case (reg_sel_e'(wrSel))
        SEL_WORD:   stb.wrWord  = 1'b1;
        SEL_TAG:    stb.wrTag   = 1'b1;
        SEL_INDEX:  stb.wrIndex = 1'b1;
        SEL_SEARCH: stb.search  = privWr;
        SEL_PID:    stb.wrPid   = privWr;
        SEL_ZONE:   stb.wrZone  = privWr;
        default:    ;
      endcase
    end
    if (rdEn && portOn) begin
      case (reg_sel_e'(rdSel))
        SEL_WORD:  stb.rdWord  = rdPerm;
        SEL_TAG: begin
          stb.rdTag   = rdPerm;
          stb.pidLoad = rdPerm;
        end
        SEL_INDEX: stb.rdIndex = 1'b1;
        SEL_PID:   stb.rdPid   = rdPerm;
        SEL_ZONE:  stb.rdZone  = rdPerm;
        default:   ;
      endcase
    end
  end

endmodule

// File: rtl/tlb_mgmt_search.sv
module tlb_mgmt_search #(
  parameter int ENTRIES    = 16,
  parameter int TID_W      = 8,
  parameter int ZONE_LIMIT = 15,
  localparam int IDXW      = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [31:0]      key,
  input  logic             userMode,
  input  logic [TID_W-1:0] pid,
  input  logic [31:0]      zpr,
  input  logic [31:0]      tags  [ENTRIES],
  input  logic [3:0]       zones [ENTRIES],
  input  logic [TID_W-1:0] tids  [ENTRIES],
  output logic             resValid,
  output logic             resHit,
  output logic [IDXW-1:0]  resIdx
);

  logic [31:0]      keyQ;
  logic             armQ;
  logic [ENTRIES-1:0] hitVec;
  logic             anyHit;
  logic [IDXW-1:0]  firstIdx;

  function automatic logic [31:0] pageMask(input logic [2:0] code);
    int sh;
    sh = 10 + 2 * int'(code);
    return ~((32'd1 << sh) - 32'd1);
  endfunction

  generate
    for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
      logic [31:0] mask;
      logic        pageEq;
      logic        tidOk;
      logic [1:0]  zoneBits;
      logic        zoneOk;
      always_comb begin
        mask     = pageMask(tags[g][9:7]);
        pageEq   = ((keyQ & mask) == (tags[g] & mask));
        tidOk    = (tids[g] == '0) || (tids[g] == pid);
        zoneBits = 2'(zpr >> (5'd30 - {zones[g], 1'b0}));
        if (int'(zones[g]) > ZONE_LIMIT) zoneBits = 2'b01;
        zoneOk   = !((zoneBits == 2'b00) && userMode);
        hitVec[g] = tags[g][6] && pageEq && tidOk && zoneOk;
      end
    end
  endgenerate

  always_comb begin
    firstIdx = '0;
    anyHit   = 1'b0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (hitVec[i]) begin
        firstIdx = IDXW'(i);
        anyHit   = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      keyQ     <= '0;
      armQ     <= 1'b0;
      resValid <= 1'b0;
      resHit   <= 1'b0;
      resIdx   <= '0;
    end else begin
      armQ <= start;
      if (start) keyQ <= key;
      resValid <= armQ;
      resHit   <= armQ && anyHit;
      resIdx   <= firstIdx;
    end
  end

endmodule

// File: rtl/tlb_mgmt_datapath.sv
module tlb_mgmt_datapath
  import tlb_mgmt_pkg::*;
#(
  parameter int ENTRIES    = 16,
  parameter int TID_W      = 8,
  parameter int ZONE_LIMIT = 15
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        userMode,
  input  ctrl_stb_t   stb,
  input  logic [31:0] wrValue,
  output logic        rdValid,
  output logic [31:0] rdData
);

  localparam int IDXW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [31:0]      tlbxQ;
  logic [TID_W-1:0] pidQ;
  logic [31:0]      zprQ;
  logic [31:0]      tagQ  [ENTRIES];
  logic [31:0]      wordQ [ENTRIES];
  logic [TID_W-1:0] tidQ  [ENTRIES];
  logic [3:0]       zoneSel [ENTRIES];

  logic [7:0]       rawIdx;
  logic             entryOk;
  logic [IDXW-1:0]  slot;
  logic [31:0]      rdMux;

  logic             resValid;
  logic             resHit;
  logic [IDXW-1:0]  resIdx;

  assign rawIdx  = tlbxQ[7:0];
  assign entryOk = ({24'b0, rawIdx} < 32'(ENTRIES));
  assign slot    = rawIdx[IDXW-1:0];

  generate
    for (genvar g = 0; g < ENTRIES; g++) begin : g_zone
      assign zoneSel[g] = wordQ[g][7:4];
    end
  endgenerate

  tlb_mgmt_search #(
    .ENTRIES(ENTRIES), .TID_W(TID_W), .ZONE_LIMIT(ZONE_LIMIT)
  ) search_i (
    .clk      (clk),
    .rstN     (rstN),
    .start    (stb.search),
    .key      (wrValue),
    .userMode (userMode),
    .pid      (pidQ),
    .zpr      (zprQ),
    .tags     (tagQ),
    .zones    (zoneSel),
    .tids     (tidQ),
    .resValid (resValid),
    .resHit   (resHit),
    .resIdx   (resIdx)
  );

  always_comb begin
    rdMux = '0;
    if (stb.rdWord && entryOk)     rdMux = wordQ[slot];
    else if (stb.rdTag && entryOk) rdMux = tagQ[slot];
    else if (stb.rdIndex)          rdMux = tlbxQ;
    else if (stb.rdPid)            rdMux = 32'(pidQ);
    else if (stb.rdZone)           rdMux = zprQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tlbxQ   <= '0;
      pidQ    <= '0;
      zprQ    <= '0;
      rdValid <= 1'b0;
      rdData  <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        tagQ[i]  <= '0;
        wordQ[i] <= '0;
        tidQ[i]  <= '0;
      end
    end else begin
      if (stb.wrTag && entryOk) begin
        tagQ[slot] <= wrValue;
        tidQ[slot] <= pidQ;
      end
      if (stb.wrWord && entryOk) wordQ[slot] <= wrValue;
      if (stb.pidLoad && entryOk) pidQ <= tidQ[slot];
      if (stb.wrPid)  pidQ <= wrValue[TID_W-1:0];
      if (stb.wrZone) zprQ <= wrValue;
      if (stb.wrIndex)       tlbxQ <= wrValue;
      else if (resValid)     tlbxQ <= resHit ? 32'(resIdx) : (tlbxQ | 32'h8000_0000);
      rdValid <= stb.rdEn;
      rdData  <= stb.rdEn ? rdMux : 32'd0;
    end
  end

endmodule

// File: rtl/tlb_mgmt_port.sv
module tlb_mgmt_port
  import tlb_mgmt_pkg::*;
#(
  parameter int ENTRIES    = 16,
  parameter int TID_W      = 8,
  parameter int ZONE_LIMIT = 15
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [1:0]  mmuMode,
  input  logic [1:0]  accessLevel,
  input  logic        userMode,
  input  logic        wrEn,
  input  logic [2:0]  wrSel,
  input  logic [31:0] wrValue,
  input  logic        rdEn,
  input  logic [2:0]  rdSel,
  output logic        rdValid,
  output logic [31:0] rdData
);

  ctrl_stb_t stb;

  tlb_mgmt_ctrl ctrl_i (
    .wrEn        (wrEn),
    .wrSel       (wrSel),
    .rdEn        (rdEn),
    .rdSel       (rdSel),
    .mmuMode     (mmuMode),
    .accessLevel (accessLevel),
    .stb         (stb)
  );

  tlb_mgmt_datapath #(
    .ENTRIES(ENTRIES), .TID_W(TID_W), .ZONE_LIMIT(ZONE_LIMIT)
  ) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .userMode (userMode),
    .stb      (stb),
    .wrValue  (wrValue),
    .rdValid  (rdValid),
    .rdData   (rdData)
  );

endmodule

// File: rtl/tlb_mgmt_port_chk.sv
module tlb_mgmt_port_chk (
  input logic        clk,
  input logic        rstN,
  input logic [1:0]  mmuMode,
  input logic [1:0]  accessLevel,
  input logic        rdEn,
  input logic [2:0]  rdSel,
  input logic        rdValid,
  input logic [31:0] rdData
);

  // R2: result strobe trails the request by one cycle
  a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rstN)
    $past(rdEn) |-> rdValid);

  // R2: no data without a valid result
  a_r2_idle_zero: assert property (@(posedge clk) disable iff (!rstN)
    !rdValid |-> (rdData == 32'd0));

  // R2: unmapped selects read as zero
  a_r2_unmapped_zero: assert property (@(posedge clk) disable iff (!rstN)
    $past(rdEn && (rdSel >= 3'd6)) |-> (rdData == 32'd0));

  // R11: gated registers read zero when level bit 0 is clear
  a_r11_gated_read_zero: assert property (@(posedge clk) disable iff (!rstN)
    $past(rdEn && !accessLevel[0] && (rdSel != 3'd2)) |-> (rdData == 32'd0));

  // R12: disabled port reads zero
  a_r12_disabled_read_zero: assert property (@(posedge clk) disable iff (!rstN)
    $past(rdEn && ((mmuMode < 2'd2) || (accessLevel == 2'd0))) |-> (rdData == 32'd0));

endmodule

bind tlb_mgmt_port tlb_mgmt_port_chk chk_i (
  .clk         (clk),
  .rstN        (rstN),
  .mmuMode     (mmuMode),
  .accessLevel (accessLevel),
  .rdEn        (rdEn),
  .rdSel       (rdSel),
  .rdValid     (rdValid),
  .rdData      (rdData)
);

// File: tb/tlb_mgmt_port_tb_top.sv
module tlb_mgmt_port_tb_top;

  localparam logic [2:0] S_WORD = 3'd0, S_TAG = 3'd1, S_IDX = 3'd2,
                         S_SRCH = 3'd3, S_PID = 3'd4, S_ZONE = 3'd5;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  mmuMode = 2'd2;
  logic [1:0]  accessLevel = 2'd3;
  logic        userMode = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  wrSel = '0;
  logic [31:0] wrValue = '0;
  logic        rdEn = 1'b0;
  logic [2:0]  rdSel = '0;
  logic        rdValid;
  logic [31:0] rdData;

  int checks = 0;
  int failures = 0;
  logic [31:0] expQ [$];
  string       tagQ [$];
  bit          finished = 1'b0;

  always #10 clk = ~clk;

  tlb_mgmt_port dut_i (
    .clk(clk), .rstN(rstN), .mmuMode(mmuMode), .accessLevel(accessLevel),
    .userMode(userMode), .wrEn(wrEn), .wrSel(wrSel), .wrValue(wrValue),
    .rdEn(rdEn), .rdSel(rdSel), .rdValid(rdValid), .rdData(rdData)
  );

  // monitor: pops expected read results as they appear
  always @(negedge clk) begin
    if (rstN && rdValid) begin
      checks++;
      if (expQ.size() == 0) begin
        failures++;
        $display("FAIL unexpected read result: actual=%h expected=none", rdData);
      end else begin
        logic [31:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        if (rdData !== e) begin
          failures++;
          $display("FAIL %s: actual=%h expected=%h", t, rdData, e);
        end
      end
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] sel, input logic [31:0] v);
    wrEn = 1'b1; wrSel = sel; wrValue = v;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [2:0] sel, input logic [31:0] e, input string t);
    expQ.push_back(e);
    tagQ.push_back(t);
    rdEn = 1'b1; rdSel = sel;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic search(input logic [31:0] v);
    wr(S_SRCH, v);
    idle(2);
  endtask

  initial begin : watchdog
    for (int i = 0; i < 100000; i++) begin
      @(posedge clk);
      if (finished) disable watchdog;
    end
    failures++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    idle(3);
    rstN = 1'b1;
    idle(1);

    // R1 reset state
    rd(S_IDX,  32'h0, "R1 index reset");
    rd(S_PID,  32'h0, "R1 pid reset");
    rd(S_ZONE, 32'h0, "R1 zone reset");
    rd(S_WORD, 32'h0, "R1 data entry0 reset");
    rd(S_TAG,  32'h0, "R1 tag entry0 reset");
    // R2 unmapped select
    rd(3'd6, 32'h0, "R2 unmapped select");
    wr(3'd7, 32'hFFFF_FFFF);
    rd(S_IDX, 32'h0, "R2 unmapped write no effect");

    // R3 array access through index, TID capture
    wr(S_IDX, 32'd3);
    wr(S_PID, 32'h25);
    wr(S_TAG, 32'h1234_5440);
    wr(S_WORD, 32'h0ABC_D005);
    rd(S_WORD, 32'h0ABC_D005, "R3 data word readback");
    rd(S_TAG,  32'h1234_5440, "R3 tag word readback");
    // R4 tag read reloads pid
    wr(S_PID, 32'h77);
    rd(S_TAG, 32'h1234_5440, "R4 tag read");
    rd(S_PID, 32'h25, "R4 pid loaded from entry");

    // R5 hit
    search(32'h1234_57FF);
    rd(S_IDX, 32'd3, "R5 search hit index");
    // R6 miss on pid mismatch
    wr(S_PID, 32'h26);
    search(32'h1234_57FF);
    rd(S_IDX, 32'h8000_0003, "R6 miss flag keeps low bits");

    // global entries 5 and 7, 16 KiB pages
    wr(S_PID, 32'h0);
    wr(S_IDX, 32'd5);
    wr(S_TAG, 32'h0040_0140);
    wr(S_WORD, 32'h0000_0000);
    wr(S_IDX, 32'd7);
    wr(S_TAG, 32'h0040_0140);
    wr(S_WORD, 32'h0000_0010);
    wr(S_PID, 32'h26);
    search(32'h0040_3ABC);
    rd(S_IDX, 32'd5, "R7 R8 size mask and lowest entry wins");
    search(32'h0040_4000);
    rd(S_IDX, 32'h8000_0005, "R7 address beyond page misses");

    // R9 zones
    wr(S_ZONE, 32'h1000_0000);
    userMode = 1'b1;
    search(32'h0040_0000);
    rd(S_IDX, 32'd7, "R9 user skips zone 00");
    userMode = 1'b0;
    search(32'h0040_0000);
    rd(S_IDX, 32'd5, "R9 supervisor ignores zone 00");

    // R10 level 1 blocks privileged writes
    accessLevel = 2'd1;
    wr(S_PID, 32'h55);
    wr(S_ZONE, 32'hFFFF_FFFF);
    wr(S_IDX, 32'd2);
    search(32'h0040_0000);
    rd(S_IDX, 32'd2, "R10 search ignored index write kept");
    accessLevel = 2'd3;
    rd(S_PID,  32'h26, "R10 pid write ignored");
    rd(S_ZONE, 32'h1000_0000, "R10 zone write ignored");

    // R11 level 2: bit0 clear
    accessLevel = 2'd2;
    wr(S_IDX, 32'd3);
    rd(S_WORD, 32'h0, "R11 data read gated");
    rd(S_TAG,  32'h0, "R11 tag read gated");
    rd(S_PID,  32'h0, "R11 pid read gated");
    rd(S_IDX,  32'd3, "R11 index still readable");
    accessLevel = 2'd3;
    rd(S_PID, 32'h26, "R11 gated tag read left pid");

    // R12 disabled port
    mmuMode = 2'd1;
    wr(S_IDX, 32'd9);
    rd(S_IDX, 32'h0, "R12 read zero when config low");
    mmuMode = 2'd2;
    rd(S_IDX, 32'd3, "R12 write ignored when config low");
    accessLevel = 2'd0;
    rd(S_IDX, 32'h0, "R12 read zero at level 0");
    wr(S_PID, 32'h11);
    accessLevel = 2'd3;
    rd(S_PID, 32'h26, "R12 write ignored at level 0");

    // R13 index range and low 8 bits
    wr(S_IDX, 32'd20);
    wr(S_WORD, 32'h0000_DEAD);
    rd(S_WORD, 32'h0, "R13 out of range read");
    rd(S_TAG,  32'h0, "R13 out of range tag read");
    wr(S_IDX, 32'd4);
    rd(S_WORD, 32'h0, "R13 out of range write not aliased");
    wr(S_IDX, 32'h8000_0103);
    rd(S_WORD, 32'h0ABC_D005, "R13 index from low 8 bits");

    // R14 direct index write collides with search result
    wr(S_SRCH, 32'h0040_0000);
    idle(1);
    wr(S_IDX, 32'h0000_000B);
    rd(S_IDX, 32'h0000_000B, "R14 direct write wins");
    idle(2);
    rd(S_IDX, 32'h0000_000B, "R14 result dropped");

    idle(3);
    if (expQ.size() != 0) begin
      failures++;
      checks++;
      $display("FAIL R2 missing results: actual=%0d expected=0", expQ.size());
    end
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule